// File: doc/BRIEF.md
# Message-Atomic Request Arbiter

This block merges the request channels of several masters onto one downstream request channel of a lightweight ready-valid memory bus. Every beat carries an opcode, a size field holding the base-2 logarithm of the payload byte count, a source tag, an address and one data word. When several masters offer requests, a round-robin choice picks one. After the first beat of a multibeat message has been accepted, the grant stays with that master until the last beat of the message has gone through. No other master can insert a beat in between.

The arbiter works out the number of beats from the header it already sees. Request opcodes 0 to 3 carry a payload and may span several beats. Opcodes 4 and 5 carry no payload and always take one beat. No length or last-beat wire is added. The downstream source field is the winning port index placed above the master's own tag, so that a separate response demultiplexer can route the answer back. The path is purely combinational. A beat passes in the same cycle it is offered.

Top module: `msg_lock_arbiter`

## Requirements
- R1: With no upstream valid asserted, including during and right after reset, `out_valid` is low and every bit of `in_ready` is low.
- R2: A beat transfers only in a cycle where `out_valid` and `out_ready` are both high. `in_ready[i]` is high only when `out_ready` is high and port i is the selected port.
- R3: The beat count of a message depends on its opcode and size. Opcodes 0 (full write), 1 (partial write), 2 (arithmetic) and 3 (logical) carry data and take max(1, 2^size / bytes-per-beat) beats; with a 64-bit data path, size 2 or 3 gives one beat and size 6 gives eight. Opcodes 4 (read) and 5 (hint) take one beat whatever the size.
- R4: Once the first beat of a multibeat message from port i is accepted, no other port receives `in_ready` until the last beat of that message is accepted.
- R5: When a message's last beat is accepted from port i, the next choice searches the ports in the order i+1, i+2, … with wrap-around. After reset the search starts at port 0.
- R6: The round-robin pointer moves only when a message's last beat is accepted. Stalled cycles (`out_ready` low) and non-final beats leave the choice unchanged.
- R7: `out_source` equals the selected port index (upper bits) concatenated with that port's source tag (lower bits).
- R8: `out_opcode`, `out_size`, `out_addr` and `out_data` are those of the selected port, passed through unchanged.
- R9: At most one bit of `in_ready` is high in any cycle.
- R10: While locked to a port whose valid is low, `out_valid` stays low even if other ports are valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N_PORTS | Per-port beat valid |
| in_ready | output | N_PORTS | Per-port beat accepted |
| in_opcode | input | 3*N_PORTS | Per-port opcode, port p at bits [3p+2:3p] |
| in_size | input | SIZE_W*N_PORTS | Per-port log2 payload size |
| in_source | input | SRC_W*N_PORTS | Per-port source tag |
| in_addr | input | ADDR_W*N_PORTS | Per-port address |
| in_data | input | DATA_W*N_PORTS | Per-port data word |
| out_valid | output | 1 | Downstream beat valid |
| out_ready | input | 1 | Downstream ready |
| out_opcode | output | 3 | Selected opcode |
| out_size | output | SIZE_W | Selected size |
| out_source | output | IDX_W+SRC_W | Port index above source tag |
| out_addr | output | ADDR_W | Selected address |
| out_data | output | DATA_W | Selected data |

## Verification
The bench builds the arbiter with three ports, a 3-bit size field and a 64-bit data word. Three ports is not a power of two, so the pointer must wrap from 2 back to 0 and index 3 is never used. The 3-bit size reaches 128-byte messages, while sizes below 3 exercise the one-beat floor. Size 6 on a logical-data message gives an eight-beat lock during which a waiting port must stay starved. Size 6 on a read must not lock at all.

// File: rtl/marb_pkg.sv
package marb_pkg;

    typedef enum logic [2:0] {
        OP_PUT_FULL = 3'd0,
        OP_PUT_PART = 3'd1,
        OP_ARITH    = 3'd2,
        OP_LOGIC    = 3'd3,
        OP_GET      = 3'd4,
        OP_HINT     = 3'd5
    } req_op_e;

    // Opcodes below the read code carry a payload.
    function automatic logic op_has_data(input logic [2:0] op);
        return op < 3'(OP_GET);
    endfunction

endpackage

// File: rtl/marb_beat_len.sv
module marb_beat_len #(
    parameter int SIZE_W   = 3,
    parameter int LG_BYTES = 3,
    parameter int CNT_W    = 4
) (
    input  logic [2:0]        opcode,
    input  logic [SIZE_W-1:0] size,
    output logic [CNT_W-1:0]  extra_beats
);
    import marb_pkg::*;

    localparam logic [SIZE_W-1:0] LGB = SIZE_W'(LG_BYTES);

    logic [SIZE_W-1:0] shift;

    // extra = 2^(size-LG_BYTES) - 1, modulo 2^CNT_W (exact for the largest size)
    always_comb begin
        shift       = size - LGB;
        extra_beats = '0;
        if (op_has_data(opcode) && (size > LGB)) begin
            extra_beats = (CNT_W'(1) << shift) - CNT_W'(1);
        end
    end

endmodule

// File: rtl/marb_rr_pick.sv
module marb_rr_pick #(
    parameter int N     = 3,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] ptr,
    output logic             hit,
    output logic [IDX_W-1:0] pick
);
    always_comb begin
        hit  = 1'b0;
        pick = '0;
        for (int k = 0; k < N; k++) begin
            int c;
            c = int'(ptr) + k;
            if (c >= N) c = c - N;
            if (!hit && req[c]) begin
                hit  = 1'b1;
                pick = IDX_W'(c);
            end
        end
    end

endmodule

// File: rtl/marb_lock_ctrl.sv
module marb_lock_ctrl #(
    parameter int N     = 3,
    parameter int IDX_W = 2,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [IDX_W-1:0] sel,
    input  logic [CNT_W-1:0] extra_beats,
    output logic             locked,
    output logic [IDX_W-1:0] owner,
    output logic [IDX_W-1:0] ptr
);
    typedef struct packed {
        logic             locked;
        logic [IDX_W-1:0] owner;
        logic [CNT_W-1:0] remain;
        logic [IDX_W-1:0] ptr;
    } lock_st_t;

    lock_st_t st_d, st_q;

    function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] i);
        return (i == IDX_W'(N - 1)) ? '0 : i + IDX_W'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (fire) begin
            if (!st_q.locked) begin
                if (extra_beats != '0) begin
                    st_d.locked = 1'b1;
                    st_d.owner  = sel;
                    st_d.remain = extra_beats;
                end else begin
                    st_d.ptr = next_idx(sel);
                end
            end else begin
                st_d.remain = st_q.remain - CNT_W'(1);
                if (st_q.remain == CNT_W'(1)) begin
                    st_d.locked = 1'b0;
                    st_d.ptr    = next_idx(st_q.owner);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked = st_q.locked;
    assign owner  = st_q.owner;
    assign ptr    = st_q.ptr;

    AST_LOCK_KEEPS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.locked && !(fire && st_q.remain == CNT_W'(1))) |=> (st_q.locked && $stable(st_q.owner))); // R4
    AST_REMAIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |-> (st_q.remain != '0)); // R3
    AST_PTR_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(st_q.ptr)); // R6
    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.ptr) < N); // R5

endmodule

// File: rtl/msg_lock_arbiter.sv
module msg_lock_arbiter #(
    parameter int N_PORTS = 3,
    parameter int SRC_W   = 4,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 64,
    parameter int SIZE_W  = 3,
    localparam int IDX_W     = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
    localparam int LG_BYTES  = $clog2(DATA_W / 8),
    localparam int MAX_SHIFT = (1 << SIZE_W) - 1 - LG_BYTES,
    localparam int CNT_W     = (MAX_SHIFT > 0) ? MAX_SHIFT : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_PORTS-1:0]          in_valid,
    output logic [N_PORTS-1:0]          in_ready,
    input  logic [3*N_PORTS-1:0]        in_opcode,
    input  logic [SIZE_W*N_PORTS-1:0]   in_size,
    input  logic [SRC_W*N_PORTS-1:0]    in_source,
    input  logic [ADDR_W*N_PORTS-1:0]   in_addr,
    input  logic [DATA_W*N_PORTS-1:0]   in_data,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [2:0]                  out_opcode,
    output logic [SIZE_W-1:0]           out_size,
    output logic [IDX_W+SRC_W-1:0]      out_source,
    output logic [ADDR_W-1:0]           out_addr,
    output logic [DATA_W-1:0]           out_data
);
    logic             locked, hit, fire;
    logic [IDX_W-1:0] owner, ptr, pick, sel;
    logic [CNT_W-1:0] extra_beats;

    marb_rr_pick #(.N(N_PORTS), .IDX_W(IDX_W)) u_pick (
        .req  (in_valid),
        .ptr  (ptr),
        .hit  (hit),
        .pick (pick)
    );

    always_comb begin
        sel        = locked ? owner : pick;
        out_valid  = locked ? in_valid[owner] : hit;
        out_opcode = in_opcode[int'(sel)*3 +: 3];
        out_size   = in_size[int'(sel)*SIZE_W +: SIZE_W];
        out_source = {sel, in_source[int'(sel)*SRC_W +: SRC_W]};
        out_addr   = in_addr[int'(sel)*ADDR_W +: ADDR_W];
        out_data   = in_data[int'(sel)*DATA_W +: DATA_W];
        fire       = out_valid && out_ready;
    end

    for (genvar g = 0; g < N_PORTS; g++) begin : g_ready
        assign in_ready[g] = fire && (sel == IDX_W'(g));

        AST_SOURCE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
            in_ready[g] |-> (out_source[SRC_W +: IDX_W] == IDX_W'(g))); // R7
    end

    marb_beat_len #(.SIZE_W(SIZE_W), .LG_BYTES(LG_BYTES), .CNT_W(CNT_W)) u_len (
        .opcode      (out_opcode),
        .size        (out_size),
        .extra_beats (extra_beats)
    );

    marb_lock_ctrl #(.N(N_PORTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire        (fire),
        .sel         (sel),
        .extra_beats (extra_beats),
        .locked      (locked),
        .owner       (owner),
        .ptr         (ptr)
    );

    AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_ready)); // R9
    AST_READY_NEEDS_DOWNSTREAM: assert property (@(posedge clk) disable iff (!rst_n)
        (|in_ready) |-> (out_ready && out_valid)); // R2
    AST_LOCKED_ONLY_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> ((in_ready & ~({{(N_PORTS-1){1'b0}}, 1'b1} << owner)) == '0)); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid == '0) |-> (!out_valid && in_ready == '0)); // R1

endmodule

// File: tb/sim_msg_lock_arbiter.sv
`timescale 1ns/1ps
module sim_msg_lock_arbiter;
    localparam int NP = 3, SW = 4, AW = 16, DW = 64, ZW = 3;

    logic clk = 1'b0, rst_n = 1'b0, out_ready = 1'b0;
    always #2.5 clk = ~clk;

    logic          v_a   [NP];
    logic [2:0]    op_a  [NP];
    logic [ZW-1:0] sz_a  [NP];
    logic [SW-1:0] src_a [NP];
    logic [AW-1:0] ad_a  [NP];
    logic [DW-1:0] dt_a  [NP];

    logic [NP-1:0]    in_valid, in_ready;
    logic [3*NP-1:0]  in_opcode;
    logic [ZW*NP-1:0] in_size;
    logic [SW*NP-1:0] in_source;
    logic [AW*NP-1:0] in_addr;
    logic [DW*NP-1:0] in_data;
    logic             out_valid;
    logic [2:0]       out_opcode;
    logic [ZW-1:0]    out_size;
    logic [SW+1:0]    out_source;
    logic [AW-1:0]    out_addr;
    logic [DW-1:0]    out_data;

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            in_valid[p]            = v_a[p];
            in_opcode[p*3 +: 3]    = op_a[p];
            in_size[p*ZW +: ZW]    = sz_a[p];
            in_source[p*SW +: SW]  = src_a[p];
            in_addr[p*AW +: AW]    = ad_a[p];
            in_data[p*DW +: DW]    = dt_a[p];
        end
    end

    msg_lock_arbiter #(.N_PORTS(NP), .SRC_W(SW), .ADDR_W(AW), .DATA_W(DW), .SIZE_W(ZW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_opcode(in_opcode), .in_size(in_size), .in_source(in_source),
        .in_addr(in_addr), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_opcode(out_opcode), .out_size(out_size),
        .out_source(out_source), .out_addr(out_addr), .out_data(out_data)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    task automatic set_port(input int p, input logic v, input logic [2:0] op,
                            input logic [ZW-1:0] sz, input logic [SW-1:0] src,
                            input logic [AW-1:0] ad, input logic [DW-1:0] dt);
        v_a[p] = v; op_a[p] = op; sz_a[p] = sz; src_a[p] = src; ad_a[p] = ad; dt_a[p] = dt;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; out_ready = 1'b0;
        for (int p = 0; p < NP; p++) set_port(p, 1'b0, 3'd0, '0, '0, '0, '0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: quiet outputs in and after reset
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int p = 0; p < NP; p++) set_port(p, 1'b0, 3'd0, '0, '0, '0, '0);
        #1;
        check("R1 valid in reset", 64'(out_valid), 64'd0);
        check("R1 ready in reset", 64'(in_ready), 64'd0);
        do_reset();
        out_ready = 1'b1;
        #1;
        check("R1 valid idle", 64'(out_valid), 64'd0);
        check("R1 ready idle", 64'(in_ready), 64'd0);
    endtask

    // R3 R4 R7 R8: eight-beat logical-data message holds off port 1
    task automatic t_long_lock();
        do_reset();
        out_ready = 1'b1;
        set_port(1, 1'b1, 3'd4, 3'd3, 4'd9, 16'h0BEE, 64'hDEAD);
        for (int k = 0; k < 8; k++) begin
            set_port(0, 1'b1, 3'd3, 3'd6, 4'd5, 16'h0100, 64'(k + 100));
            #1;
            check("R4 lock ready", 64'(in_ready), 64'b001);
            check("R8 data", out_data, 64'(k + 100));
            check("R7 source", 64'(out_source), {58'd0, 2'd0, 4'd5});
            @(negedge clk);
        end
        set_port(0, 1'b0, 3'd0, '0, '0, '0, '0);
        #1;
        check("R3 eight beats then free", 64'(in_ready), 64'b010);
        check("R7 source port1", 64'(out_source), {58'd0, 2'd1, 4'd9});
        check("R8 addr", 64'(out_addr), 64'h0BEE);
        check("R8 opcode", 64'(out_opcode), 64'd4);
        check("R8 size", 64'(out_size), 64'd3);
    endtask

    // R3 R5: small write is a single beat; pointer passes to the next port
    task automatic t_single_beat_write();
        do_reset();
        out_ready = 1'b1;
        set_port(0, 1'b1, 3'd0, 3'd2, 4'd1, 16'h0010, 64'h11);
        set_port(1, 1'b1, 3'd4, 3'd0, 4'd2, 16'h0020, 64'h22);
        #1;
        check("R5 first pick port0", 64'(in_ready), 64'b001);
        @(negedge clk);
        #1;
        check("R3 size2 one beat / R5 rotate", 64'(in_ready), 64'b010);
        @(negedge clk);
        set_port(1, 1'b0, 3'd0, '0, '0, '0, '0);
        #1;
        check("R5 wrap past idle port2", 64'(in_ready), 64'b001);
    endtask

    // R3 R5 R9: reads and hints never lock; three-way rotation wraps
    task automatic t_no_data_ops();
        do_reset();
        out_ready = 1'b1;
        set_port(0, 1'b1, 3'd4, 3'd6, 4'd3, 16'h0A00, 64'h0);
        set_port(1, 1'b1, 3'd5, 3'd7, 4'd4, 16'h0B00, 64'h0);
        set_port(2, 1'b1, 3'd1, 3'd3, 4'd6, 16'h0C00, 64'h77);
        #1; check("R3 read size6 one beat", 64'(in_ready), 64'b001);
        @(negedge clk); #1; check("R3 read no lock", 64'(in_ready), 64'b010);
        @(negedge clk); #1; check("R3 hint no lock R9", 64'(in_ready), 64'b100);
        @(negedge clk); #1; check("R5 wrap to port0", 64'(in_ready), 64'b001);
    endtask

    // R2 R6 R10: stalls inside a locked two-beat message
    task automatic t_locked_stall();
        do_reset();
        out_ready = 1'b1;
        set_port(0, 1'b1, 3'd0, 3'd4, 4'd7, 16'h0300, 64'hA);
        set_port(2, 1'b1, 3'd4, 3'd3, 4'd8, 16'h0400, 64'h0);
        #1; check("R4 first beat port0", 64'(in_ready), 64'b001);
        @(negedge clk);
        v_a[0] = 1'b0;
        #1;
        check("R10 owner gap valid", 64'(out_valid), 64'd0);
        check("R10 owner gap ready", 64'(in_ready), 64'd0);
        @(negedge clk);
        set_port(0, 1'b1, 3'd0, 3'd4, 4'd7, 16'h0300, 64'hB);
        out_ready = 1'b0;
        #1;
        check("R2 stall valid", 64'(out_valid), 64'd1);
        check("R2 stall no ready", 64'(in_ready), 64'd0);
        check("R6 stall keeps owner", out_data, 64'hB);
        @(negedge clk);
        out_ready = 1'b1;
        #1; check("R4 last beat port0", 64'(in_ready), 64'b001);
        @(negedge clk);
        v_a[0] = 1'b0;
        #1;
        check("R5 after release port2", 64'(in_ready), 64'b100);
        check("R7 source port2", 64'(out_source), {58'd0, 2'd2, 4'd8});
    endtask

    // R6: unlocked stalls do not move the pointer
    task automatic t_idle_stall();
        do_reset();
        out_ready = 1'b0;
        for (int p = 0; p < NP; p++) set_port(p, 1'b1, 3'd4, 3'd3, 4'(p), 16'(p), 64'(p));
        for (int c = 0; c < 2; c++) begin
            #1;
            check("R6 stall selection port0", 64'(out_source[5:4]), 64'd0);
            check("R2 no ready when stalled", 64'(in_ready), 64'd0);
            @(negedge clk);
        end
        out_ready = 1'b1;
        #1; check("R6 fire port0", 64'(in_ready), 64'b001);
        @(negedge clk); #1; check("R5 then port1", 64'(in_ready), 64'b010);
        @(negedge clk);
        out_ready = 1'b0;
        #1; check("R6 stall selection port2", 64'(out_source[5:4]), 64'd2);
        @(negedge clk);
        out_ready = 1'b1;
        #1; check("R6 fire port2", 64'(in_ready), 64'b100);
    endtask

    initial begin
        for (int p = 0; p < NP; p++) set_port(p, 1'b0, 3'd0, '0, '0, '0, '0);
        t_reset();
        t_long_lock();
        t_single_beat_write();
        t_no_data_ops();
        t_locked_stall();
        t_idle_stall();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule